// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Capture Controller

This block sits on the device side of a byte-wide parallel EEPROM. It turns the host's asynchronous active-low chip-select, write-enable and output-enable strobes into write cycles on one system clock. It brings the strobes and the address and data buses into the clock domain through two-flop synchronisers. The address is latched at the moment the two write strobes first become low together. The data is latched at the moment they stop being low together. Each captured byte goes into a page buffer, at the slot given by the low address bits.

A falling edge of write-enable opens a collection window, or restarts it if one is already open. Once no new falling edge arrives for the whole window, the block sends the collected page to the array in a one-cycle program request. The request carries the page address, a byte-valid mask and the buffered bytes. The block then reports busy for a fixed program time. While it is busy, strobe activity is ignored. The buffer is emptied when busy ends. Both durations are given in microseconds and converted to clock counts from the clock-frequency parameter.

Top module: `eeprom_page_writer`

## Requirements
- R1: A byte is captured only when output-enable is high and both chip-select and write-enable are low. A strobe cycle made with output-enable low leaves the buffer empty and produces no program request.
- R2: The address is taken at the clock on which the second of chip-select or write-enable is seen low. Later address changes within the same cycle have no effect.
- R3: The data is the value present on the last synchronised clock on which both strobes were low, before the first of them rises. Data changes made together with or after that rise are not stored.
- R4: A write-enable falling edge, with output-enable high and the block not busy, starts a window of W = CLK_HZ/1e6 × WINDOW_US clocks. Counting the first rising clock edge that samples write-enable low as edge 1, prog_req_o goes high just after edge W+3.
- R5: A further write-enable falling edge inside the window restarts it from zero, so the timing of R4 runs from the last falling edge.
- R6: prog_req_o is high for exactly one cycle. In that cycle, prog_page_o holds address bits above PAGE_BITS of the first byte in the window. Bit i of prog_mask_o is set exactly when offset i was written. prog_data_o[8i+7:8i] holds the last byte written to offset i, and unwritten slots read zero.
- R7: A byte whose upper address bits differ from the window's page is dropped.
- R8: busy_o rises together with prog_req_o and stays high for exactly P = CLK_HZ/1e6 × PROG_US clocks.
- R9: While busy_o is high, write cycles store nothing and start no window. When busy_o falls, the mask and buffer are cleared, so the next window starts empty.
- R10: A window that closes with no byte captured (for example, a write-enable pulse with chip-select high) produces no program request and no busy.
- R11: After reset, busy_o, prog_req_o and prog_mask_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| busy_o | output | 1 | Program phase in progress |
| prog_req_o | output | 1 | One-cycle program request to the array |
| prog_page_o | output | ADDR_W-PAGE_BITS | Page address of the request |
| prog_mask_o | output | 2**PAGE_BITS | Byte-valid mask |
| prog_data_o | output | DATA_W*2**PAGE_BITS | Buffered page bytes, offset 0 in the low bits |

## Verification
The bench changes the address bus after the second strobe falls and the data bus at the moment the first strobe rises. It runs both strobe orderings. A design that latched on the wrong edge would store junk address or junk data.

Retriggered windows are checked by their exact request cycle, counted from the last write-enable fall. A plain one-shot would fire too early. A bad synchroniser count would be off by one.

Writes made during busy must leave busy timing unchanged and produce no later request. A design that let them through would retrigger the window or leak bytes into the next page. Off-page bytes, writes with output-enable low and empty windows must all leave the mask as predicted.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1_000_000;
    return (c == 0) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/eepw_sync.sv
module eepw_sync #(
  parameter int unsigned    W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eepw_oneshot.sv
module eepw_oneshot #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= CW'(CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  // last counting cycle, unless retriggered in it
  assign done_o   = (cnt_q == CW'(1)) && !fire_i;
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int unsigned PAGE_BITS = 6,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned NB       = 1 << PAGE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic [PAGE_BITS-1:0] off_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [NB-1:0]        mask_o,
  output logic [NB*DATA_W-1:0] data_o
);
  for (genvar g = 0; g < NB; g++) begin : g_slot
    logic              vld_q;
    logic [DATA_W-1:0] byte_q;
    logic              hit;

    assign hit = wr_i && (off_i == PAGE_BITS'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        byte_q <= '0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
        byte_q <= '0;
      end else if (hit) begin
        vld_q  <= 1'b1;
        byte_q <= data_i;
      end
    end

    assign mask_o[g]                    = vld_q;
    assign data_o[g*DATA_W +: DATA_W]   = byte_q;
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned     WINDOW_US = 150,
  parameter int unsigned     PROG_US   = 6000,
  parameter int unsigned     ADDR_W    = 17,
  parameter int unsigned     DATA_W    = 8,
  parameter int unsigned     PAGE_BITS = 6,
  localparam int unsigned    PAGE_BYTES = 1 << PAGE_BITS,
  localparam int unsigned    PG_W       = ADDR_W - PAGE_BITS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         we_ni,
  input  logic                         oe_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic                         busy_o,
  output logic                         prog_req_o,
  output logic [PG_W-1:0]              prog_page_o,
  output logic [PAGE_BYTES-1:0]        prog_mask_o,
  output logic [PAGE_BYTES*DATA_W-1:0] prog_data_o
);
  import eepw_pkg::*;

  localparam int unsigned WIN_CYC  = us_to_cycles(CLK_HZ, WINDOW_US);
  localparam int unsigned PROG_CYC = us_to_cycles(CLK_HZ, PROG_US);
  localparam int unsigned BUS_W    = ADDR_W + DATA_W;

  logic cs_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  eepw_sync #(.W(3), .RST(3'b111)) u_strb_sync (
    .clk_i, .rst_ni,
    .d_i ({oe_ni, we_ni, cs_ni}),
    .q_o ({oe_s, we_s, cs_s})
  );

  // buses take the same latency so they line up with the strobes
  eepw_sync #(.W(BUS_W), .RST('0)) u_bus_sync (
    .clk_i, .rst_ni,
    .d_i ({addr_i, data_i}),
    .q_o ({addr_s, data_s})
  );

  logic both_low, both_low_q, we_q, armed_q, open_q;
  logic cyc_start, cyc_end, we_fell, page_hit, buf_wr;
  logic [ADDR_W-1:0] addr_lat_q;
  logic [DATA_W-1:0] data_lat_q;
  logic [PG_W-1:0]   page_q;
  logic win_active, win_done, prog_fire, prog_done, prog_req_q;

  assign both_low  = !cs_s && !we_s;
  assign cyc_start = both_low && !both_low_q && oe_s && !busy_o;
  assign cyc_end   = !both_low && both_low_q && oe_s && armed_q && !busy_o;
  assign we_fell   = !we_s && we_q && oe_s && !busy_o;
  assign page_hit  = !open_q || (addr_lat_q[ADDR_W-1:PAGE_BITS] == page_q);
  assign buf_wr    = cyc_end && page_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      both_low_q <= 1'b0;
      we_q       <= 1'b1;
      armed_q    <= 1'b0;
      addr_lat_q <= '0;
      data_lat_q <= '0;
    end else begin
      both_low_q <= both_low;
      we_q       <= we_s;
      if (cyc_start)                 armed_q <= 1'b1;
      else if (cyc_end || busy_o)    armed_q <= 1'b0;
      if (cyc_start) addr_lat_q <= addr_s;
      if (both_low)  data_lat_q <= data_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (prog_done) begin
      open_q <= 1'b0;
    end else if (buf_wr && !open_q) begin
      open_q <= 1'b1;
      page_q <= addr_lat_q[ADDR_W-1:PAGE_BITS];
    end
  end

  eepw_page_buf #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .clr_i  (prog_done),
    .wr_i   (buf_wr),
    .off_i  (addr_lat_q[PAGE_BITS-1:0]),
    .data_i (data_lat_q),
    .mask_o (prog_mask_o),
    .data_o (prog_data_o)
  );

  eepw_oneshot #(.CYC(WIN_CYC)) u_win (
    .clk_i, .rst_ni,
    .fire_i   (we_fell),
    .active_o (win_active),
    .done_o   (win_done)
  );

  assign prog_fire = win_done && (prog_mask_o != '0);

  eepw_oneshot #(.CYC(PROG_CYC)) u_prog (
    .clk_i, .rst_ni,
    .fire_i   (prog_fire),
    .active_o (busy_o),
    .done_o   (prog_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_req_q <= 1'b0;
    else         prog_req_q <= prog_fire;
  end

  assign prog_req_o  = prog_req_q;
  assign prog_page_o = page_q;

  logic unused_win;
  assign unused_win = win_active;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk #(
  parameter int unsigned NB = 64,
  parameter int unsigned PW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          prog_req_o,
  input logic [NB-1:0] prog_mask_o,
  input logic [PW-1:0] prog_page_o
);
  assert_req_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

  assert_req_has_bytes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (prog_mask_o != '0));

  assert_busy_starts_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> prog_req_o);

  assert_req_sets_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> busy_o);

  assert_page_frozen_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(prog_mask_o) && $stable(prog_page_o)));

  assert_cleared_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (prog_mask_o == '0));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(.NB(PAGE_BYTES), .PW(PG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .prog_req_o  (prog_req_o),
  .prog_mask_o (prog_mask_o),
  .prog_page_o (prog_page_o)
);

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam longint unsigned CLK_HZ = 50_000_000;
  localparam int unsigned WIN_US = 2, PROG_US = 4;
  localparam int unsigned AW = 12, DW = 8, PB = 4;
  localparam int unsigned NB = 1 << PB;
  localparam int W = int'(CLK_HZ / 1_000_000) * WIN_US;
  localparam int P = int'(CLK_HZ / 1_000_000) * PROG_US;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, preq;
  logic [AW-PB-1:0] ppage;
  logic [NB-1:0] pmask;
  logic [NB*DW-1:0] pdata;

  eeprom_page_writer #(.CLK_HZ(CLK_HZ), .WINDOW_US(WIN_US), .PROG_US(PROG_US),
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .busy_o(busy), .prog_req_o(preq),
    .prog_page_o(ppage), .prog_mask_o(pmask), .prog_data_o(pdata));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, last_we = 0;
  bit done = 0;
  logic [NB-1:0] m_mask;
  logic [NB*DW-1:0] m_data;
  logic [AW-PB-1:0] m_page;
  bit m_open;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic void model_clear();
    m_mask = '0; m_data = '0; m_open = 0; m_page = '0;
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!m_open) begin m_open = 1; m_page = a[AW-1:PB]; end
    if (a[AW-1:PB] == m_page) begin
      m_mask[a[PB-1:0]] = 1'b1;
      m_data[a[PB-1:0]*DW +: DW] = d;
    end
  endfunction

  task automatic write_byte(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit cs_last, input bit cs_first, input bit oe_low);
    oe_n = oe_low ? 1'b0 : 1'b1;
    addr = AW'($urandom); data = DW'($urandom);
    tick();
    if (cs_last) begin
      we_n = 1'b0; last_we = cyc; tick(2); addr = a; cs_n = 1'b0;
    end else begin
      cs_n = 1'b0; tick(2); addr = a; we_n = 1'b0; last_we = cyc;
    end
    tick(3);
    addr = ~a; data = d;
    tick(3);
    data = ~d;
    if (cs_first) cs_n = 1'b1; else we_n = 1'b1;
    tick(2);
    cs_n = 1'b1; we_n = 1'b1;
    tick(2);
    oe_n = 1'b1;
    if (!oe_low && !busy) model_write(a, d);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (preq || busy) seen = 1; end
    check(!seen, req, 128'(seen), 128'(0));
  endtask

  // waits for request, checks contents and timing, returns request cycle
  task automatic expect_prog(input string req, output int rq);
    int t = 0;
    rq = -1;
    while (!preq && t < W + 60) begin tick(); t++; end
    check(preq, "R4", 128'(preq), 128'(1));
    if (!preq) return;
    rq = cyc;
    check(cyc - last_we == W + 3, "R4/R5", 128'(cyc - last_we), 128'(W + 3));
    check(ppage == m_page, {req, "/R6 page"}, 128'(ppage), 128'(m_page));
    check(pmask == m_mask, {req, "/R6 mask"}, 128'(pmask), 128'(m_mask));
    check(pdata == m_data, {req, "/R6 data R2 R3"}, 128'(pdata), 128'(m_data));
    check(busy, "R8", 128'(busy), 128'(1));
    tick();
    check(!preq, "R6", 128'(preq), 128'(0));
  endtask

  task automatic wait_busy_end(input int rq);
    while (busy) tick();
    check(cyc - rq == P, "R8", 128'(cyc - rq), 128'(P));
    check(pmask == '0, "R9", 128'(pmask), 128'(0));
    model_clear();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int rq;
    void'($urandom(32'd4242));
    model_clear();
    tick(5);
    check(!busy && !preq && pmask == '0, "R11", 128'({busy, preq, pmask}), 128'(0));
    rst_ni = 1'b1;
    tick(2);
    check(!busy && !preq && pmask == '0, "R11", 128'({busy, preq, pmask}), 128'(0));

    // R2 R3 both strobe orderings, two bytes
    write_byte(12'h3A5, 8'h5C, 1'b0, 1'b1, 1'b0);
    write_byte(12'h3A2, 8'hE1, 1'b1, 1'b0, 1'b0);
    expect_prog("R2", rq);
    wait_busy_end(rq);

    // R5 retrigger with gap inside the window; R7 off-page byte dropped
    write_byte(12'h105, 8'h11, 1'b0, 1'b0, 1'b0);
    tick(W - 40);
    write_byte(12'h205, 8'h22, 1'b1, 1'b1, 1'b0);
    tick(W - 40);
    write_byte(12'h10F, 8'h33, 1'b0, 1'b1, 1'b0);
    write_byte(12'h105, 8'h44, 1'b1, 1'b0, 1'b0);
    expect_prog("R5 R7", rq);
    // R9 write during busy is ignored
    write_byte(12'h777, 8'h99, 1'b0, 1'b0, 1'b0);
    wait_busy_end(rq);
    expect_quiet(W + 20, "R9");

    // R1 output-enable low
    write_byte(12'h050, 8'hAA, 1'b0, 1'b0, 1'b1);
    expect_quiet(W + 20, "R1");
    check(pmask == '0, "R1", 128'(pmask), 128'(0));

    // R10 write-enable pulse with chip-select high
    we_n = 1'b0; tick(4); we_n = 1'b1;
    expect_quiet(W + 20, "R10");

    // R9 next window starts clean
    write_byte(12'h6C3, 8'h7E, 1'b1, 1'b1, 1'b0);
    expect_prog("R9", rq);
    wait_busy_end(rq);

    for (int w = 0; w < 20; w++) begin
      logic [AW-PB-1:0] pg = (AW-PB)'($urandom);
      int nb = 1 + int'($urandom % 5);
      for (int b = 0; b < nb; b++) begin
        logic [AW-PB-1:0] p2 = (b > 0 && ($urandom % 6 == 0)) ? pg + 1'b1 : pg;
        write_byte({p2, PB'($urandom)}, DW'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        if ($urandom % 3 == 0) tick(int'($urandom % 50));
      end
      expect_prog("R6", rq);
      wait_busy_end(rq);
    end

    done = 1;
    finish_run();
  end
endmodule